// File: doc/BRIEF.md
# Saturating 40-bit multiply-accumulate unit

This block is the arithmetic coprocessor for a 16-bit processor. It multiplies two signed 16-bit operands and loads, adds or clears a 40-bit accumulator. The top eight bits of the accumulator are guard bits above a 32-bit working range. The accumulator can also be shifted arithmetically by eight bits in either direction. Six condition flags are kept in a status word. With saturation enabled, any result that leaves the 32-bit working range is clamped to the nearest 32-bit limit.

A limited-store output always presents the high 16 bits of the 32-bit working range. If the accumulator has grown into the guard bits, that output is replaced by the signed 16-bit extreme. Software sets up the unit through a small register port: status, control, repeat count, and a read-only view of the accumulator's low word. An operation accepted while the repeat count is above one runs again on every following cycle with the same operands, and busy stays high meanwhile. A maskable interrupt output follows selected flags and cuts a repeat sequence short.

Top module: `macAcc`

## Requirements
- R1: After reset the accumulator, status, control and repeat words are zero, and busy, irq and storeOut are low.
- R2: opCode values: 1 clears the accumulator, 2 loads the sign-extended signed product opA*opB, and 3 adds that product to the accumulator. Values 0, 6 and 7 leave the accumulator and status unchanged. An accepted operation takes effect at the clock edge that samples opValid.
- R3: Status bits are E=bit0, Z=bit1, N=bit2, V=bit3, SL=bit4 and SV=bit5. After an operation, E is set when bits 39..31 of the accumulator are not all equal. Z is set for a zero accumulator and N equals bit 39. V is set when the operation overflowed 40 bits, or when a left shift lost significant bits. SV is ORed with V and SL is ORed with the saturation event. SV and SL stay set until software writes the status word.
- R4: opCode 4 shifts the accumulator left by 8 bits, and V is set when bits 39..31 were not all equal before the shift. opCode 5 is an arithmetic right shift by 8 bits that clears V.
- R5: With control bit0 (saturation) set, a result that overflows 40 bits or does not fit 32 signed bits becomes 0x007FFFFFFF or 0xFF80000000, chosen by the sign of the true result, and SL is set.
- R6: storeOut equals accumulator bits 31..16 when E is 0. When E is 1 it is 0x7FFF if N is 0 and 0x8000 if N is 1. Reading it or any register changes no state.
- R7: Register addresses are 0 for status (bits 5..0), 1 for control (bit0 saturation, bits 13..8 interrupt mask) and 2 for the repeat count (bits 12..0). Address 3 reads the accumulator bits 15..0 and ignores writes. Unused bits read 0.
- R8: When the repeat count C is 2 or more at acceptance, the operation runs C times on consecutive cycles with the same operands. busy is high for the C-1 cycles after acceptance, and the repeat count drops by one per run until it reaches 0. A count of 0 or 1 gives a single run and leaves 0.
- R9: While busy is high, opValid and register writes are ignored. In an idle cycle with opValid high, a register write in the same cycle is dropped.
- R10: irq is the OR of status bits ANDed with the control mask bits 13..8, aligned bit for bit. If irq is high in a repeat cycle, that cycle runs nothing, busy falls, and the repeat count keeps the runs still owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation strobe |
| opCode | input | 3 | Operation select |
| opA | input | 16 | Signed multiplicand |
| opB | input | 16 | Signed multiplier |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWData | input | 16 | Register write data |
| regRData | output | 16 | Register read data, combinational on regAddr |
| storeOut | output | 16 | Limited high word of the accumulator |
| busy | output | 1 | Repeat sequence in progress |
| irq | output | 1 | Masked flag interrupt |

## Verification
The checks assume that software writes the status word only while the unit is idle and no operation is offered. They also assume that the repeat count is loaded before the operation it is meant to repeat, not in the same cycle. The stimulus does drive operations and register writes in the same cycle, and during busy, but only to show that the unit drops them. Random operands are mixed with the extremes 0x7FFF and 0x8000 so that guard-bit growth, 40-bit overflow and clamping are all reached. Repeat counts stay small so that sequences end quickly. The interrupt mask is randomised, so some sequences are halted early.

// File: rtl/macPkg.sv
package macPkg;
  parameter int OP_W    = 16;
  parameter int ACC_W   = 40;
  parameter int SHIFT_W = 8;
  parameter int CNT_W   = 13;
  parameter int FLAG_W  = 6;

  localparam int FL_E  = 0;
  localparam int FL_Z  = 1;
  localparam int FL_N  = 2;
  localparam int FL_V  = 3;
  localparam int FL_SL = 4;
  localparam int FL_SV = 5;
  localparam int MASK_LSB = 8;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_CLR  = 3'd1,
    OP_MUL  = 3'd2,
    OP_MAC  = 3'd3,
    OP_SHL  = 3'd4,
    OP_SHR  = 3'd5,
    OP_RES6 = 3'd6,
    OP_RES7 = 3'd7
  } macOp_e;

  typedef struct packed {
    logic   exec;
    logic   load;
    macOp_e op;
  } macStrobe_t;
endpackage

// File: rtl/macDatapath.sv
module macDatapath
  import macPkg::*;
#(
  parameter int OPW  = OP_W,
  parameter int ACCW = ACC_W,
  parameter int SHW  = SHIFT_W,
  parameter int FLW  = FLAG_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  macStrobe_t      strb,
  input  logic [OPW-1:0]  opA,
  input  logic [OPW-1:0]  opB,
  input  logic            satEn,
  input  logic            stWr,
  input  logic [FLW-1:0]  stWData,
  output logic [ACCW-1:0] acc,
  output logic [FLW-1:0]  status
);
  localparam int HI_W  = 2 * OPW;
  localparam int EXT_W = ACCW - HI_W;
  localparam logic [ACCW-1:0] SAT_POS = {{(EXT_W + 1){1'b0}}, {(HI_W - 1){1'b1}}};
  localparam logic [ACCW-1:0] SAT_NEG = ~SAT_POS;

  logic [OPW-1:0] aReg, bReg, curA, curB;
  logic signed [HI_W-1:0] prod;
  logic [ACCW-1:0] prodX, rawRes, res;
  logic [ACCW:0]   sum;
  logic            ovf, trueNeg, satHit, isArith;

  function automatic logic fitsHi(input logic [ACCW-1:0] v);
    return (&v[ACCW-1:HI_W-1]) | ~(|v[ACCW-1:HI_W-1]);
  endfunction

  assign curA  = strb.load ? opA : aReg;
  assign curB  = strb.load ? opB : bReg;
  assign prod  = $signed(curA) * $signed(curB);
  assign prodX = {{EXT_W{prod[HI_W-1]}}, prod};
  assign sum   = {acc[ACCW-1], acc} + {prodX[ACCW-1], prodX};

  always_comb begin
    rawRes  = acc;
    ovf     = 1'b0;
    isArith = 1'b1;
    case (strb.op)
      OP_CLR:  rawRes = '0;
      OP_MUL:  rawRes = prodX;
      OP_MAC: begin
        rawRes = sum[ACCW-1:0];
        ovf    = sum[ACCW] ^ sum[ACCW-1];
      end
      OP_SHL: begin
        rawRes = acc << SHW;
        ovf    = ~((&acc[ACCW-1:ACCW-1-SHW]) | ~(|acc[ACCW-1:ACCW-1-SHW]));
      end
      OP_SHR:  rawRes = $signed(acc) >>> SHW;
      default: isArith = 1'b0;
    endcase
    case (strb.op)
      OP_MAC:  trueNeg = sum[ACCW];
      OP_SHL:  trueNeg = acc[ACCW-1];
      default: trueNeg = rawRes[ACCW-1];
    endcase
    satHit = satEn & (ovf | ~fitsHi(rawRes));
    res    = satHit ? (trueNeg ? SAT_NEG : SAT_POS) : rawRes;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc    <= '0;
      status <= '0;
      aReg   <= '0;
      bReg   <= '0;
    end else begin
      if (strb.load) begin
        aReg <= opA;
        bReg <= opB;
      end
      if (stWr) begin
        status <= stWData;
      end else if (strb.exec && isArith) begin
        acc          <= res;
        status[FL_E] <= ~fitsHi(res);
        status[FL_Z] <= (res == '0);
        status[FL_N] <= res[ACCW-1];
        status[FL_V] <= ovf;
        status[FL_SL] <= status[FL_SL] | satHit;
        status[FL_SV] <= status[FL_SV] | ovf;
      end
    end
  end
endmodule

// File: rtl/macCtrl.sv
module macCtrl
  import macPkg::*;
#(
  parameter int OPW = OP_W,
  parameter int CW  = CNT_W,
  parameter int FLW = FLAG_W
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           opValid,
  input  logic [2:0]     opCode,
  input  logic           regWr,
  input  logic [1:0]     regAddr,
  input  logic [OPW-1:0] regWData,
  input  logic [FLW-1:0] status,
  output macStrobe_t     strb,
  output logic           satEn,
  output logic           stWr,
  output logic [OPW-1:0] ctlWord,
  output logic [CW-1:0]  repWord,
  output logic           busy,
  output logic           irq
);
  localparam logic [OPW-1:0] CTL_MASK = OPW'({{FLW{1'b1}}, {(MASK_LSB - 1){1'b0}}, 1'b1});

  logic   running, accept, regOk;
  macOp_e opReg;

  assign accept = opValid & ~running;
  assign regOk  = regWr & ~running & ~opValid;
  assign irq    = |(ctlWord[MASK_LSB +: FLW] & status);
  assign satEn  = ctlWord[0];
  assign busy   = running;
  assign stWr   = regOk & (regAddr == 2'd0);

  assign strb.load = accept;
  assign strb.exec = accept | (running & ~irq);
  assign strb.op   = accept ? macOp_e'(opCode) : opReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      repWord <= '0;
      ctlWord <= '0;
      opReg   <= OP_NOP;
    end else if (accept) begin
      opReg   <= macOp_e'(opCode);
      repWord <= (repWord != '0) ? repWord - 1'b1 : '0;
      running <= (repWord > CW'(1));
    end else if (running) begin
      if (irq) begin
        running <= 1'b0;
      end else begin
        repWord <= repWord - 1'b1;
        running <= (repWord != CW'(1));
      end
    end else if (regOk) begin
      if (regAddr == 2'd1) ctlWord <= regWData & CTL_MASK;
      if (regAddr == 2'd2) repWord <= regWData[CW-1:0];
    end
  end
endmodule

// File: rtl/macAcc.sv
module macAcc
  import macPkg::*;
#(
  parameter int OPW  = OP_W,
  parameter int ACCW = ACC_W,
  parameter int CW   = CNT_W
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           opValid,
  input  logic [2:0]     opCode,
  input  logic [OPW-1:0] opA,
  input  logic [OPW-1:0] opB,
  input  logic           regWr,
  input  logic [1:0]     regAddr,
  input  logic [OPW-1:0] regWData,
  output logic [OPW-1:0] regRData,
  output logic [OPW-1:0] storeOut,
  output logic           busy,
  output logic           irq
);
  localparam int FLW = FLAG_W;

  macStrobe_t      strb;
  logic            satEn, stWr;
  logic [OPW-1:0]  ctlWord;
  logic [CW-1:0]   repWord;
  logic [ACCW-1:0] acc;
  logic [FLW-1:0]  status;

  macCtrl #(.OPW(OPW), .CW(CW), .FLW(FLW)) u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .regWr(regWr), .regAddr(regAddr), .regWData(regWData), .status(status),
    .strb(strb), .satEn(satEn), .stWr(stWr), .ctlWord(ctlWord),
    .repWord(repWord), .busy(busy), .irq(irq)
  );

  macDatapath #(.OPW(OPW), .ACCW(ACCW), .SHW(SHIFT_W), .FLW(FLW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .opA(opA), .opB(opB),
    .satEn(satEn), .stWr(stWr), .stWData(regWData[FLW-1:0]),
    .acc(acc), .status(status)
  );

  always_comb begin
    case (regAddr)
      2'd0:    regRData = OPW'(status);
      2'd1:    regRData = ctlWord;
      2'd2:    regRData = OPW'(repWord);
      default: regRData = acc[OPW-1:0];
    endcase
    if (status[FL_E]) storeOut = status[FL_N] ? {1'b1, {(OPW-1){1'b0}}} : {1'b0, {(OPW-1){1'b1}}};
    else              storeOut = acc[2*OPW-1:OPW];
  end
endmodule

// File: rtl/macAccChk.sv
module macAccChk
  import macPkg::*;
#(
  parameter int CW  = CNT_W,
  parameter int FLW = FLAG_W
) (
  input logic           clk,
  input logic           rstN,
  input logic           busy,
  input logic           irq,
  input logic           regWr,
  input logic [1:0]     regAddr,
  input logic           opValid,
  input logic [FLW-1:0] status,
  input logic [CW-1:0]  repWord,
  input logic           satEn,
  input macStrobe_t     strb
);
  logic swStWrite, arithExec;
  assign swStWrite = regWr & (regAddr == 2'd0) & ~busy & ~opValid;
  assign arithExec = strb.exec & (strb.op inside {OP_CLR, OP_MUL, OP_MAC, OP_SHL, OP_SHR});

  a_r3_sv_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (status[FL_SV] && !swStWrite) |=> status[FL_SV]);

  a_r3_sl_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (status[FL_SL] && !swStWrite) |=> status[FL_SL]);

  a_r4_shr_clears_v: assert property (@(posedge clk) disable iff (!rstN)
    (strb.exec && strb.op == OP_SHR) |=> !status[FL_V]);

  a_r5_sat_fits: assert property (@(posedge clk) disable iff (!rstN)
    (satEn && arithExec) |=> !status[FL_E]);

  a_r8_countdown: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !irq) |=> (repWord == $past(repWord) - 1'b1));

  a_r10_halt: assert property (@(posedge clk) disable iff (!rstN)
    (busy && irq) |=> (!busy && $stable(repWord)));
endmodule

bind macAcc macAccChk #(.CW(CW), .FLW(FLAG_W)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .irq(irq), .regWr(regWr),
  .regAddr(regAddr), .opValid(opValid), .status(status), .repWord(repWord),
  .satEn(satEn), .strb(strb)
);

// File: tb/macAcc_tb.sv
`timescale 1ns/1ps
module macAcc_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0;
  logic [2:0] opCode = 3'd0;
  logic [15:0] opA = 16'd0, opB = 16'd0;
  logic regWr = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [15:0] regWData = 16'd0;
  logic [15:0] regRData, storeOut;
  logic busy, irq;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  // bench model state
  logic [39:0] mAcc;
  logic [5:0]  mSt;
  logic [15:0] mCtl;
  logic [12:0] mRep;
  logic        mRun;
  logic [2:0]  mOp;
  logic [15:0] mA, mB;

  macAcc u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .opA(opA),
    .opB(opB), .regWr(regWr), .regAddr(regAddr), .regWData(regWData),
    .regRData(regRData), .storeOut(storeOut), .busy(busy), .irq(irq)
  );

  always #2.5 clk = ~clk;

  function automatic logic fit32(input logic [39:0] v);
    return (v[39:31] == 9'h000) || (v[39:31] == 9'h1FF);
  endfunction

  function automatic logic mIrq();
    return |(mCtl[13:8] & mSt);
  endfunction

  task automatic mReset();
    mAcc = '0; mSt = '0; mCtl = '0; mRep = '0; mRun = 1'b0;
    mOp = '0; mA = '0; mB = '0;
  endtask

  task automatic mExec(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b);
    logic signed [31:0] pp;
    logic [39:0] p, r;
    logic [40:0] s;
    logic v, neg, sat;
    pp = $signed(a) * $signed(b);
    p  = {{8{pp[31]}}, pp};
    v  = 1'b0;
    case (op)
      3'd1: r = '0;
      3'd2: r = p;
      3'd3: begin
        s = {mAcc[39], mAcc} + {p[39], p};
        r = s[39:0];
        v = s[40] != s[39];
      end
      3'd4: begin
        r = {mAcc[31:0], 8'h00};
        v = !fit32(mAcc);
      end
      3'd5: r = {{8{mAcc[39]}}, mAcc[39:8]};
      default: return;
    endcase
    if (op == 3'd3) neg = s[40];
    else if (op == 3'd4) neg = mAcc[39];
    else neg = r[39];
    sat = mCtl[0] && (v || !fit32(r));
    if (sat) r = neg ? 40'hFF80000000 : 40'h007FFFFFFF;
    mSt  = {mSt[5] | v, mSt[4] | sat, v, r[39], r == 40'd0, !fit32(r)};
    mAcc = r;
  endtask

  task automatic mClock();
    logic [12:0] c;
    if (mRun) begin
      if (mIrq()) mRun = 1'b0;
      else begin
        mExec(mOp, mA, mB);
        mRep = mRep - 13'd1;
        mRun = (mRep != 13'd0);
      end
    end else if (opValid) begin
      mOp = opCode; mA = opA; mB = opB;
      mExec(mOp, mA, mB);
      c = mRep;
      mRep = (c != 0) ? c - 13'd1 : 13'd0;
      mRun = (c > 13'd1);
    end else if (regWr) begin
      case (regAddr)
        2'd0: mSt = regWData[5:0];
        2'd1: mCtl = regWData & 16'h3F01;
        2'd2: mRep = regWData[12:0];
        default: ;
      endcase
    end
  endtask

  task automatic chk(input string tag, input string what, input logic [39:0] act, input logic [39:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareAll(input string tag);
    logic [1:0] saveAddr;
    logic [15:0] expStore;
    saveAddr = regAddr;
    expStore = mSt[0] ? (mSt[2] ? 16'h8000 : 16'h7FFF) : mAcc[31:16];
    chk(tag, "busy", 40'(busy), 40'(mRun));
    chk(tag, "irq", 40'(irq), 40'(mIrq()));
    chk(tag, "storeOut", 40'(storeOut), 40'(expStore));
    regAddr = 2'd0; #0.2; chk(tag, "status", 40'(regRData), 40'({10'd0, mSt}));
    regAddr = 2'd1; #0.2; chk(tag, "control", 40'(regRData), 40'(mCtl));
    regAddr = 2'd2; #0.2; chk(tag, "repeat", 40'(regRData), 40'({3'd0, mRep}));
    regAddr = 2'd3; #0.2; chk(tag, "accLow", 40'(regRData), 40'(mAcc[15:0]));
    regAddr = saveAddr;
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    mClock();
    @(negedge clk);
    compareAll(tag);
    opValid = 1'b0;
    regWr = 1'b0;
  endtask

  task automatic doOp(input logic [2:0] c, input logic [15:0] a, input logic [15:0] b, input string tag);
    opValid = 1'b1; opCode = c; opA = a; opB = b;
    step(tag);
  endtask

  task automatic doWr(input logic [1:0] ad, input logic [15:0] d, input string tag);
    regWr = 1'b1; regAddr = ad; regWData = d;
    step(tag);
  endtask

  task automatic drain(input string tag);
    while (mRun) step(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nErrors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7731));
    mReset();
    repeat (3) @(negedge clk);
    compareAll("R1");
    rstN = 1'b1;
    step("R1");

    // R7 register map and masking
    doWr(2'd1, 16'hFFFF, "R7");
    doWr(2'd2, 16'hFFFF, "R7");
    doWr(2'd0, 16'hFFFF, "R7");
    doWr(2'd3, 16'h1234, "R7");
    doWr(2'd0, 16'h0000, "R7");
    doWr(2'd1, 16'h0000, "R7");
    doWr(2'd2, 16'h0000, "R7");

    // R2 basic arithmetic
    doOp(3'd2, 16'h1234, 16'h0056, "R2");
    doOp(3'd3, 16'hFFFD, 16'h0007, "R2");
    doOp(3'd3, 16'h8000, 16'h8000, "R2");
    doOp(3'd6, 16'h1111, 16'h2222, "R2");
    doOp(3'd0, 16'h1111, 16'h2222, "R2");
    doOp(3'd7, 16'h1111, 16'h2222, "R2");
    doOp(3'd1, 16'h0000, 16'h0000, "R2");

    // R3 flags, growth into guard bits, overflow and sticky clearing
    doOp(3'd2, 16'h7FFF, 16'h7FFF, "R3");
    doOp(3'd3, 16'h7FFF, 16'h7FFF, "R3");
    doOp(3'd3, 16'h7FFF, 16'h7FFF, "R6");
    doOp(3'd4, 16'h0000, 16'h0000, "R3");
    doOp(3'd4, 16'h0000, 16'h0000, "R3");
    doOp(3'd3, 16'h8000, 16'h7FFF, "R3");
    step("R6");
    doWr(2'd0, 16'h0000, "R3");

    // R4 shifts
    doOp(3'd2, 16'h0100, 16'h0001, "R4");
    doOp(3'd4, 16'h0000, 16'h0000, "R4");
    doOp(3'd5, 16'h0000, 16'h0000, "R4");
    doOp(3'd2, 16'h8000, 16'h0123, "R4");
    doOp(3'd5, 16'h0000, 16'h0000, "R4");
    doOp(3'd5, 16'h0000, 16'h0000, "R4");

    // R5 saturation
    doWr(2'd1, 16'h0001, "R5");
    doOp(3'd2, 16'h7FFF, 16'h7FFF, "R5");
    doOp(3'd3, 16'h7FFF, 16'h7FFF, "R5");
    doOp(3'd3, 16'h7FFF, 16'h7FFF, "R5");
    doOp(3'd2, 16'h8000, 16'h7FFF, "R5");
    doOp(3'd3, 16'h8000, 16'h7FFF, "R5");
    doOp(3'd3, 16'h8000, 16'h7FFF, "R5");
    doOp(3'd2, 16'h0123, 16'h4567, "R5");
    doOp(3'd4, 16'h0000, 16'h0000, "R5");
    doWr(2'd1, 16'h0000, "R5");
    doWr(2'd0, 16'h0000, "R5");

    // R6 negative limit and idle reads
    doOp(3'd2, 16'h8000, 16'h7FFF, "R6");
    doOp(3'd3, 16'h8000, 16'h7FFF, "R6");
    doOp(3'd3, 16'h8000, 16'h7FFF, "R6");
    repeat (3) step("R6");

    // R8 repeat
    doWr(2'd2, 16'd5, "R8");
    doOp(3'd3, 16'd3, 16'd4, "R8");
    drain("R8");
    doWr(2'd2, 16'd1, "R8");
    doOp(3'd3, 16'd3, 16'd4, "R8");
    doOp(3'd3, 16'd3, 16'd4, "R8");

    // R9 ignored inputs while busy, and dropped write beside an op
    doWr(2'd2, 16'd6, "R9");
    doOp(3'd2, 16'h0010, 16'h0020, "R9");
    doOp(3'd1, 16'h0000, 16'h0000, "R9");
    doWr(2'd1, 16'h3F01, "R9");
    doWr(2'd0, 16'h003F, "R9");
    doWr(2'd2, 16'h0100, "R9");
    drain("R9");
    regWr = 1'b1; regAddr = 2'd1; regWData = 16'h0001;
    doOp(3'd2, 16'h0002, 16'h0003, "R9");

    // R10 interrupt halts a repeat sequence
    doWr(2'd1, 16'h0100, "R10");
    doOp(3'd1, 16'h0000, 16'h0000, "R10");
    doWr(2'd2, 16'd10, "R10");
    doOp(3'd3, 16'h7FFF, 16'h7FFF, "R10");
    drain("R10");
    doWr(2'd0, 16'h0000, "R10");
    doOp(3'd5, 16'h0000, 16'h0000, "R10");
    drain("R10");
    doWr(2'd1, 16'h0000, "R10");

    // random phase
    for (int i = 0; i < 600; i++) begin
      int kind;
      logic [15:0] ra, rb;
      kind = $urandom % 12;
      ra = ($urandom % 4 == 0) ? (($urandom % 2) ? 16'h7FFF : 16'h8000) : 16'($urandom);
      rb = ($urandom % 4 == 0) ? (($urandom % 2) ? 16'h7FFF : 16'h8000) : 16'($urandom);
      if (kind == 0) doWr(2'd0, 16'($urandom % 64), "R3");
      else if (kind == 1) doWr(2'd1, 16'($urandom), "R10");
      else if (kind == 2) doWr(2'd2, 16'($urandom % 5), "R8");
      else if (kind == 3) step("R6");
      else begin
        logic [2:0] c;
        c = 3'($urandom);
        if (c == 3'd4 || c == 3'd5) doOp(c, ra, rb, "R4");
        else doOp(c, ra, rb, "R2");
        while (mRun) begin
          if ($urandom % 3 == 0) begin
            opValid = 1'b1; opCode = 3'($urandom); opA = 16'($urandom);
          end
          if ($urandom % 3 == 0) begin
            regWr = 1'b1; regAddr = 2'($urandom); regWData = 16'($urandom);
          end
          step("R9");
        end
      end
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end
endmodule